// File: doc/BRIEF.md
# Warp Store Address Coalescer

This block accepts one store request issued for a whole group of lanes and converts the per-lane byte addresses into the smallest set of memory transactions the memory side accepts. Each lane supplies an address, an access-size code and an active bit. The coalescer drops masked or badly aligned lanes. It then gathers the surviving lanes by 128-byte line and, for each line, sends transactions whose four-bit segment mask names the 32-byte pieces of that line that are actually written.

Transactions leave one per cycle over a valid/ready pair. The final transaction of a request is marked, and a replay count travels with each transaction. Alongside, the block reports which active lanes it rejected for alignment. It also reports which lanes hold the write that takes effect when several lanes target the same byte address. A new request is taken only after every transaction of the previous one has been accepted.

Top module: `store_coalescer`

## Requirements
- R1: A transaction names a line by `txn_line` = address >> 7 and carries `txn_seg`, where bit k covers bytes 32k to 32k+31 of that line. Its segments are only those touched by surviving lanes, and the union of a line's transactions equals the set of touched segments.
- R2: If all four segments of a line are touched, the line goes out as one transaction with mask 4'b1111. Otherwise a half whose two segments are both touched goes out as one transaction (4'b0011 or 4'b1100), and every other touched segment goes out alone with a one-hot mask.
- R3: Lines leave in ascending line order. Within a line, transactions leave in ascending segment position.
- R4: At most one transaction is accepted per cycle. While `txn_valid` is high and `txn_ready` is low, `txn_line`, `txn_seg` and `txn_last` hold their values.
- R5: `txn_last` is high only on the final transaction of a request. `txn_replays` equals the number of transactions of the same request already accepted, so on the final one it is N-1.
- R6: A lane whose `req_mask` bit is 0 contributes nothing. A request with no surviving lane is accepted and produces no transaction.
- R7: The size code s (0 to 4) means 2^s bytes, and the address must be a multiple of 2^s. An active lane that has a code of 5 to 7 or a misaligned address sets its `bad_mask` bit and is dropped.
- R8: `win_mask` marks each surviving lane whose full address matches no higher-numbered surviving lane, so the highest-numbered lane wins a collision.
- R9: `req_ready` is high exactly when no transaction is outstanding. After reset `req_ready` is 1, `txn_valid` is 0, and both masks are 0. The masks update on acceptance and hold until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted |
| req_mask | input | LANES | Active lanes |
| req_addr | input | LANES*ADDR_W | Byte address per lane, lane i at bits i*ADDR_W |
| req_size | input | LANES*3 | Size code per lane, lane i at bits i*3 |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Transaction taken |
| txn_line | output | ADDR_W-7 | 128-byte line number |
| txn_seg | output | 4 | Segments carried |
| txn_last | output | 1 | Final transaction of the request |
| txn_replays | output | $clog2(LANES+1) | Earlier transactions of this request |
| bad_mask | output | LANES | Active lanes rejected for size or alignment |
| win_mask | output | LANES | Lanes whose write takes effect |

## Verification
On every cycle, the assertions check that each segment mask has one of the seven legal shapes and that a stalled transaction holds still. They also check that the replay count steps by one between transactions of one request, that no transaction is shown while a request may be taken, and that rejected and winning lanes never overlap. Only the bench scenarios can show the rest. These are the minimal transaction set, the ascending line and segment order, the collision winner under every mask, and the alignment rejection, each compared against a list the bench builds itself.

// File: rtl/store_coalescer.sv
module store_coalescer #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [LANES-1:0]           req_mask,
  input  logic [LANES*ADDR_W-1:0]    req_addr,
  input  logic [LANES*3-1:0]         req_size,
  output logic                       txn_valid,
  input  logic                       txn_ready,
  output logic [ADDR_W-8:0]          txn_line,
  output logic [3:0]                 txn_seg,
  output logic                       txn_last,
  output logic [$clog2(LANES+1)-1:0] txn_replays,
  output logic [LANES-1:0]           bad_mask,
  output logic [LANES-1:0]           win_mask
);
  localparam int LW = ADDR_W - 7;
  localparam int CW = $clog2(LANES+1);

  logic [LW-1:0]    lane_line [LANES];
  logic [3:0]       lane_seg  [LANES];
  logic [LANES-1:0] pend;
  logic [3:0]       done_seg;
  logic [CW-1:0]    cnt;

  logic [ADDR_W-1:0] a_in [LANES];
  logic [LANES-1:0]  good, win;
  logic [LW-1:0]     best;
  logic [LANES-1:0]  in_line;
  logic [3:0]        segs, rem, emit;
  logic              accept, fire, line_end;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [2:0] s;
      logic [4:0] lo;
      a_in[i] = req_addr[i*ADDR_W +: ADDR_W];
      s       = req_size[i*3 +: 3];
      lo      = (5'd1 << s) - 5'd1;
      good[i] = req_mask[i] && (s <= 3'd4) && ((a_in[i][4:0] & lo) == 5'd0);
    end
    for (int i = 0; i < LANES; i++) begin
      win[i] = good[i];
      for (int j = i + 1; j < LANES; j++)
        if (good[j] && a_in[j] == a_in[i]) win[i] = 1'b0;
    end
  end

  always_comb begin
    logic found;
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < LANES; i++)
      if (pend[i] && (!found || lane_line[i] < best)) begin
        best  = lane_line[i];
        found = 1'b1;
      end
    segs = 4'd0;
    for (int i = 0; i < LANES; i++) begin
      in_line[i] = pend[i] && lane_line[i] == best;
      if (in_line[i]) segs = segs | lane_seg[i];
    end
    rem = segs & ~done_seg;
    if (rem == 4'hF)            emit = 4'hF;
    else if (rem[1:0] == 2'b11) emit = 4'h3;
    else if (rem[0])            emit = 4'h1;
    else if (rem[1])            emit = 4'h2;
    else if (rem[3:2] == 2'b11) emit = 4'hC;
    else if (rem[2])            emit = 4'h4;
    else                        emit = 4'h8;
  end

  assign line_end    = (rem & ~emit) == 4'd0;
  assign txn_valid   = |pend;
  assign req_ready   = ~txn_valid;
  assign accept      = req_valid & req_ready;
  assign fire        = txn_valid & txn_ready;
  assign txn_line    = best;
  assign txn_seg     = emit;
  assign txn_last    = line_end && (pend & ~in_line) == '0;
  assign txn_replays = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      done_seg <= '0;
      cnt      <= '0;
      bad_mask <= '0;
      win_mask <= '0;
      for (int i = 0; i < LANES; i++) begin
        lane_line[i] <= '0;
        lane_seg[i]  <= '0;
      end
    end else if (accept) begin
      pend     <= good;
      done_seg <= '0;
      cnt      <= '0;
      bad_mask <= req_mask & ~good;
      win_mask <= win;
      for (int i = 0; i < LANES; i++) begin
        lane_line[i] <= a_in[i][ADDR_W-1:7];
        lane_seg[i]  <= 4'd1 << a_in[i][6:5];
      end
    end else if (fire) begin
      cnt <= cnt + 1'b1;
      if (line_end) begin
        pend     <= pend & ~in_line;
        done_seg <= '0;
      end else begin
        done_seg <= done_seg | emit;
      end
    end
  end
endmodule

module coalescer_chk #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       req_ready,
  input logic                       txn_valid,
  input logic                       txn_ready,
  input logic [ADDR_W-8:0]          txn_line,
  input logic [3:0]                 txn_seg,
  input logic                       txn_last,
  input logic [$clog2(LANES+1)-1:0] txn_replays,
  input logic [LANES-1:0]           bad_mask,
  input logic [LANES-1:0]           win_mask
);
  a_r2_seg_shape: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ($countones(txn_seg) == 1 || txn_seg == 4'h3 ||
                   txn_seg == 4'hC || txn_seg == 4'hF));

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_line) &&
                                $stable(txn_seg) && $stable(txn_last));

  a_r5_replay_step: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_ready && !txn_last |=>
      txn_valid && txn_replays == $past(txn_replays) + 1'b1);

  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && txn_valid));

  a_r8_win_not_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (win_mask & bad_mask) == '0);
endmodule

bind store_coalescer coalescer_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_store_coalescer.sv
module sim_store_coalescer;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 8;
  localparam int ADDR_W = 12;
  localparam int CW     = $clog2(LANES+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [LANES-1:0] req_mask = '0;
  logic [LANES*ADDR_W-1:0] req_addr = '0;
  logic [LANES*3-1:0] req_size = '0;
  logic txn_valid, txn_ready = 1'b0;
  logic [ADDR_W-8:0] txn_line;
  logic [3:0] txn_seg;
  logic txn_last;
  logic [CW-1:0] txn_replays;
  logic [LANES-1:0] bad_mask, win_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_coalescer #(.LANES(LANES), .ADDR_W(ADDR_W)) u0 (.*);

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;
  int unsigned seed = 32'h1234_5677;

  logic [ADDR_W-1:0] a [LANES];
  logic [2:0] sz [LANES];
  logic [LANES-1:0] m;

  int exp_line [32];
  int exp_seg  [32];
  int n_exp;

  function automatic int unsigned rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic check(bit ok, string r, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic push_txn(int line, int seg);
    exp_line[n_exp] = line;
    exp_seg[n_exp]  = seg;
    n_exp++;
  endtask

  task automatic run_req();
    logic [LANES-1:0] ok, wn, left;
    int k;
    for (int i = 0; i < LANES; i++)
      ok[i] = m[i] && sz[i] <= 4 && (int'(a[i]) % (1 << sz[i])) == 0;
    for (int i = 0; i < LANES; i++) begin
      wn[i] = ok[i];
      for (int j = i + 1; j < LANES; j++)
        if (ok[j] && a[j] == a[i]) wn[i] = 0;
    end
    n_exp = 0;
    left = ok;
    while (left != 0) begin
      int mn, sg;
      mn = 1 << 30; sg = 0;
      for (int i = 0; i < LANES; i++)
        if (left[i] && int'(a[i] / 128) < mn) mn = int'(a[i] / 128);
      for (int i = 0; i < LANES; i++)
        if (left[i] && int'(a[i] / 128) == mn) begin
          sg |= 1 << ((a[i] % 128) / 32);
          left[i] = 0;
        end
      if (sg == 15) push_txn(mn, 15);
      else begin
        if ((sg & 3) == 3) push_txn(mn, 3);
        else for (int b = 0; b < 2; b++) if (sg[b]) push_txn(mn, 1 << b);
        if ((sg & 12) == 12) push_txn(mn, 12);
        else for (int b = 2; b < 4; b++) if (sg[b]) push_txn(mn, 1 << b);
      end
    end

    for (int i = 0; i < LANES; i++) begin
      req_addr[i*ADDR_W +: ADDR_W] = a[i];
      req_size[i*3 +: 3] = sz[i];
    end
    req_mask = m;
    check(req_ready == 1, "R9", "ready before request", req_ready, 1);
    req_valid = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    check(bad_mask == (m & ~ok), "R7", "bad_mask", bad_mask, m & ~ok);
    check(win_mask == wn, "R8", "win_mask", win_mask, wn);

    k = 0;
    for (int g = 0; g < 400 && k < n_exp; g++) begin
      txn_ready = (rnd() % 4) != 0;
      if (!txn_valid) begin
        check(0, "R6", "missing transaction", 0, 1);
        k = n_exp;
      end else if (txn_ready) begin
        check(txn_line == exp_line[k], "R3", "line", txn_line, exp_line[k]);
        check(txn_seg == exp_seg[k], "R2", "segments", txn_seg, exp_seg[k]);
        check(txn_last == (k == n_exp - 1), "R5", "last", txn_last, k == n_exp - 1);
        check(txn_replays == k, "R5", "replays", txn_replays, k);
        k++;
      end
      @(posedge clk); @(negedge clk);
    end
    txn_ready = 0;
    check(k == n_exp, "R1", "transaction count", k, n_exp);
    check(txn_valid == 0, "R6", "no extra transaction", txn_valid, 0);
    check(req_ready == 1, "R9", "ready after drain", req_ready, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R9", "reset ready", req_ready, 1);
    check(txn_valid == 0, "R9", "reset valid", txn_valid, 0);
    check(bad_mask == 0 && win_mask == 0, "R9", "reset masks", bad_mask | win_mask, 0);

    // R6 R8 R2: every mask over a colliding four-segment pattern
    for (int mm = 0; mm < 256; mm++) begin
      for (int i = 0; i < LANES; i++) begin
        a[i] = 12'h200 + 12'(((i * 3) & 3) * 32) + 12'(i >> 2) * 12'd0;
        sz[i] = 3'd2;
      end
      m = 8'(mm);
      run_req();
    end

    // R1 R3: sixteen-byte lanes walking across line boundaries
    for (int base = 0; base < 24; base++) begin
      for (int i = 0; i < LANES; i++) begin
        a[i] = 12'(base * 16 + i * 16);
        sz[i] = 3'd4;
      end
      m = 8'hFF;
      run_req();
    end

    // R8: every lane on one address, all masks
    for (int mm = 0; mm < 256; mm++) begin
      for (int i = 0; i < LANES; i++) begin
        a[i] = 12'h3F0;
        sz[i] = 3'(i % 5);
      end
      m = 8'(mm);
      run_req();
    end

    // R7 R2 R3: scattered addresses with mixed and illegal sizes
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < LANES; i++) begin
        int unsigned r;
        r = rnd();
        sz[i] = 3'(r % 6);
        a[i] = 12'(r >> 8);
        if ((r >> 20) % 5 != 0 && sz[i] <= 4)
          a[i] = a[i] & ~12'((1 << sz[i]) - 1);
        if (t % 3 == 0) a[i] = {4'h5, a[i][7:0]};
      end
      m = 8'(rnd());
      run_req();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule